// File: doc/BRIEF.md
# Inter-Processor Block Copy Engine

This block moves a block of words from one processor's private local data memory into another processor's private local data memory. Each of those memories is dual-ported. The engine owns the spare port of each memory outright, so nothing has to arbitrate for access. Once a transfer starts, the copy runs to completion without any help from either processor. There is one transfer channel.

A processor programs a transfer over a blocking stream command channel. Each command word carries a two-bit tag:

- 0 is the source start address.
- 1 is the destination start address.
- 2 is the word count.
- 3 is go.

The fields must arrive in that order. After the copy, the engine returns one status byte on a stream status channel. A processor that waits on this channel is stalled until the byte is there, and that stall is the synchronization between the two processors.

The source port reads with a latency of one cycle. The engine overlaps each read with the write of the word read in the cycle before, so a transfer of N words occupies N+1 cycles.

Top module: `xfer_dma_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `sts_valid`, `rd_en` and `wr_en` are 0.
- R2: Command fields are taken only in the order tag 0 (source start), then tag 1 (destination start), then tag 2 (count). A field that arrives out of order is ignored. A go (tag 3) is ignored unless all three fields are held, and an ignored go causes no memory access and no status.
- R3: A successful transfer writes source word `src+i` to destination address `dst+i` for every i below the count. It writes no other destination address.
- R4: The first read is issued in the cycle after the go is accepted, and exactly count reads follow on consecutive cycles with ascending addresses. Each write appears in the cycle after its read.
- R5: While a transfer is being copied or its status is pending, `cmd_ready` is 0.
- R6: A successful transfer returns the status byte 0x01 (bit 0 = done, bit 1 = error). `sts_valid` and `sts_data` stay stable until `sts_ready` takes the byte.
- R7: A transfer is refused with status 0x03, and with no read or write, in any of these cases:
  - the count is zero;
  - `src + count` exceeds 2^AW;
  - `dst + count` exceeds 2^AW.
- R8: Once a status byte is taken, all stored fields are dropped. A go that arrives before the fields are sent again is ignored.
- R9: Write addresses start at `dst` and rise by one per written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Engine accepts a command word |
| cmd_tag | input | 2 | 0 source start, 1 destination start, 2 count, 3 go |
| cmd_data | input | DW | Field value (low bits used) |
| sts_valid | output | 1 | Status byte present |
| sts_ready | input | 1 | Processor takes the status byte |
| sts_data | output | 8 | Bit 0 done, bit 1 error |
| rd_en | output | 1 | Read strobe to source memory port |
| rd_addr | output | AW | Source read address |
| rd_data | input | DW | Source read data, one cycle after `rd_en` |
| wr_en | output | 1 | Write strobe to destination memory port |
| wr_addr | output | AW | Destination write address |
| wr_data | output | DW | Destination write data |

## Verification
The bench first sends go commands before the fields are complete, and sends fields out of order. A design that counted words instead of checking tags would start a copy from stale addresses.

It then tests refusal at the exact top of memory. A region that just fits must copy, and one that overruns by a single word must be refused with no access. An off-by-one in the end check would either wrap writes to address 0 or reject a legal block.

It also holds back `sts_ready` and checks that the status byte stays put and that commands stay blocked. It checks that a bare go after a finished transfer does nothing, which would fail in a design that kept the old fields armed.

Every write is compared against a scoreboard. The bench also checks the read timing, which catches a design that idles a cycle per word or skips the pipeline slot.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        TAG_SRC = 2'd0,
        TAG_DST = 2'd1,
        TAG_CNT = 2'd2,
        TAG_GO  = 2'd3
    } cmd_tag_e;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_COPY   = 2'd1,
        ENG_REPORT = 2'd2
    } eng_state_e;

    localparam int STS_W        = 8;
    localparam int STS_DONE_BIT = 0;
    localparam int STS_ERR_BIT  = 1;

endpackage

// File: rtl/dma_cmd_intake.sv
module dma_cmd_intake
    import dma_xfer_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [1:0]    tag,
    input  logic [DW-1:0] data,
    input  logic          clear,
    output logic          launch,
    output logic          launch_err,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt
);
    localparam int            EW   = AW + 2;
    localparam logic [EW-1:0] SPAN = EW'(1) << AW;

    typedef struct packed {
        logic [1:0]    have;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
    } fld_t;

    fld_t          fld_q, fld_d;
    logic [EW-1:0] src_top_d, dst_top_d;

    always_comb begin
        fld_d = fld_q;
        if (take) begin
            case (tag)
                TAG_SRC: if (fld_q.have == 2'd0) begin
                    fld_d.src  = data[AW-1:0];
                    fld_d.have = 2'd1;
                end
                TAG_DST: if (fld_q.have == 2'd1) begin
                    fld_d.dst  = data[AW-1:0];
                    fld_d.have = 2'd2;
                end
                TAG_CNT: if (fld_q.have == 2'd2) begin
                    fld_d.cnt  = data[CW-1:0];
                    fld_d.have = 2'd3;
                end
                default: ;
            endcase
        end
        if (clear) begin
            fld_d.have = 2'd0;
        end
        src_top_d  = EW'(fld_q.src) + EW'(fld_q.cnt);
        dst_top_d  = EW'(fld_q.dst) + EW'(fld_q.cnt);
        launch     = take && (tag == TAG_GO) && (fld_q.have == 2'd3);
        launch_err = (fld_q.cnt == '0) || (src_top_d > SPAN) || (dst_top_d > SPAN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign src = fld_q.src;
    assign dst = fld_q.dst;
    assign cnt = fld_q.cnt;

    AST_SURPLUS_FIELD_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tag != TAG_GO && fld_q.have == 2'd3 && !clear) |=> (fld_q.have == 2'd3 && $stable(fld_q.cnt))); // R2

endmodule

// File: rtl/dma_copy_pipe.sv
module dma_copy_pipe #(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [CW-1:0] cnt,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          finish
);
    typedef struct packed {
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] rd_left;
        logic [AW-1:0] wr_ptr;
        logic          wr_pend;
        logic          wr_last;
    } pipe_t;

    pipe_t pipe_q, pipe_d;

    always_comb begin
        pipe_d  = pipe_q;
        rd_en   = (pipe_q.rd_left != '0);
        rd_addr = pipe_q.rd_ptr;
        wr_en   = pipe_q.wr_pend;
        wr_addr = pipe_q.wr_ptr;
        wr_data = rd_data;
        finish  = pipe_q.wr_pend && pipe_q.wr_last;

        if (start) begin
            pipe_d.rd_ptr  = src;
            pipe_d.rd_left = cnt;
            pipe_d.wr_ptr  = dst;
            pipe_d.wr_pend = 1'b0;
            pipe_d.wr_last = 1'b0;
        end else begin
            if (rd_en) begin
                pipe_d.rd_ptr  = pipe_q.rd_ptr + 1'b1;
                pipe_d.rd_left = pipe_q.rd_left - 1'b1;
            end
            pipe_d.wr_pend = rd_en;
            pipe_d.wr_last = rd_en && (pipe_q.rd_left == CW'(1));
            if (pipe_q.wr_pend) begin
                pipe_d.wr_ptr = pipe_q.wr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    AST_RD_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1)); // R4

    AST_WR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1)); // R9

endmodule

// File: rtl/xfer_dma_engine.sv
module xfer_dma_engine
    import dma_xfer_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_tag,
    input  logic [DW-1:0]    cmd_data,
    output logic             sts_valid,
    input  logic             sts_ready,
    output logic [STS_W-1:0] sts_data,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    rd_data,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data
);
    localparam int CW = AW + 1;

    typedef struct packed {
        eng_state_e       state;
        logic [STS_W-1:0] sts;
    } eng_t;

    eng_t          eng_q, eng_d;
    logic          take, launch, launch_err, start, finish, clear;
    logic [AW-1:0] f_src, f_dst;
    logic [CW-1:0] f_cnt;

    assign cmd_ready = (eng_q.state == ENG_IDLE);
    assign take      = cmd_valid && cmd_ready;
    assign sts_valid = (eng_q.state == ENG_REPORT);
    assign sts_data  = eng_q.sts;

    dma_cmd_intake #(.AW(AW), .DW(DW), .CW(CW)) u_intake (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .tag        (cmd_tag),
        .data       (cmd_data),
        .clear      (clear),
        .launch     (launch),
        .launch_err (launch_err),
        .src        (f_src),
        .dst        (f_dst),
        .cnt        (f_cnt)
    );

    dma_copy_pipe #(.AW(AW), .DW(DW), .CW(CW)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .src     (f_src),
        .dst     (f_dst),
        .cnt     (f_cnt),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .finish  (finish)
    );

    always_comb begin
        eng_d = eng_q;
        start = 1'b0;
        clear = 1'b0;
        case (eng_q.state)
            ENG_IDLE: begin
                if (launch) begin
                    if (launch_err) begin
                        eng_d.state = ENG_REPORT;
                        eng_d.sts   = '0;
                        eng_d.sts[STS_DONE_BIT] = 1'b1;
                        eng_d.sts[STS_ERR_BIT]  = 1'b1;
                    end else begin
                        start       = 1'b1;
                        eng_d.state = ENG_COPY;
                    end
                end
            end
            ENG_COPY: begin
                if (finish) begin
                    eng_d.state = ENG_REPORT;
                    eng_d.sts   = '0;
                    eng_d.sts[STS_DONE_BIT] = 1'b1;
                end
            end
            ENG_REPORT: begin
                if (sts_ready) begin
                    clear       = 1'b1;
                    eng_d.state = ENG_IDLE;
                end
            end
            default: eng_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q.state <= ENG_IDLE;
            eng_q.sts   <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_en)); // R4

    AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> !cmd_ready); // R5

    AST_STS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid && !sts_ready) |=> (sts_valid && $stable(sts_data))); // R6

    AST_NO_ACCESS_AT_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |-> (!rd_en && !wr_en)); // R7

endmodule

// File: tb/tb_xfer_dma_engine.sv
module tb_xfer_dma_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_tag = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          sts_valid;
    logic          sts_ready = 1'b1;
    logic [7:0]    sts_data;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    xfer_dma_engine #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_tag(cmd_tag), .cmd_data(cmd_data),
        .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_data(sts_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [DW-1:0] src_mem [DEPTH];
    logic [DW-1:0] dst_mem [DEPTH];

    always @(posedge clk) begin
        if (rd_en) rd_data <= src_mem[rd_addr];
        if (wr_en) dst_mem[wr_addr] <= wr_data;
    end

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } wr_item_t;

    wr_item_t   exp_wr[$];
    logic [7:0] exp_sts[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_seen = 0;
    int first_rd = 0;
    int last_rd = 0;
    int go_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] sentinel(input int a);
        return 32'hDEAD_0000 ^ DW'(a);
    endfunction

    // monitor: pops scoreboard entries as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) begin
                if (rd_seen == 0) first_rd = cyc;
                last_rd = cyc;
                rd_seen++;
            end
            if (wr_en) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R3", "unexpected write addr", wr_addr, 0);
                end else begin
                    wr_item_t it;
                    it = exp_wr.pop_front();
                    chk(wr_addr == it.a, "R9", "write addr", wr_addr, it.a);
                    chk(wr_data == it.d, "R3", "write data", wr_data, it.d);
                end
            end
            if (sts_valid && sts_ready) begin
                if (exp_sts.size() == 0) begin
                    chk(1'b0, "R6", "unexpected status", sts_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_sts.pop_front();
                    chk(sts_data == e, "R6 R7", "status byte", sts_data, e);
                end
            end
        end
    end

    // called right after a negedge; returns at the negedge after acceptance
    task automatic send(input logic [1:0] t, input logic [DW-1:0] d);
        cmd_tag   = t;
        cmd_data  = d;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic expect_copy(input int src, input int dst, input int cnt, input bit err);
        for (int a = 0; a < DEPTH; a++) dst_mem[a] = sentinel(a);
        for (int i = 0; i < cnt && src + i < DEPTH; i++)
            src_mem[src+i] = {8'hC3, 8'(cnt), 16'(src + i)} ^ DW'(dst * 7);
        if (!err) begin
            for (int i = 0; i < cnt; i++) begin
                wr_item_t it;
                it.a = AW'(dst + i);
                it.d = src_mem[src+i];
                exp_wr.push_back(it);
            end
            exp_sts.push_back(8'h01);
        end else begin
            exp_sts.push_back(8'h03);
        end
        rd_seen = 0;
    endtask

    task automatic finish_xfer(input int dst, input int cnt, input bit err, input bit hold);
        bit rdy_bad = 1'b0;
        bit hold_bad = 1'b0;
        go_cyc = cyc;
        if (hold) begin
            sts_ready = 1'b0;
            while (!sts_valid) begin
                if (cmd_ready) rdy_bad = 1'b1;
                @(negedge clk);
            end
            for (int k = 0; k < 4; k++) begin
                if (!sts_valid || sts_data != 8'h01 || cmd_ready) hold_bad = 1'b1;
                @(negedge clk);
            end
            chk(!hold_bad, "R6", "status held while sts_ready low", hold_bad, 0);
            sts_ready = 1'b1;
        end
        while (exp_sts.size() != 0) begin
            if (cmd_ready && (rd_en || wr_en || sts_valid)) rdy_bad = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
        chk(!rdy_bad, "R5", "cmd_ready while busy", rdy_bad, 0);
        chk(exp_wr.size() == 0, "R3", "missing writes", exp_wr.size(), 0);
        if (!err) begin
            chk(rd_seen == cnt, "R4", "read count", rd_seen, cnt);
            chk(first_rd == go_cyc, "R4", "first read cycle", first_rd, go_cyc);
            chk(last_rd - first_rd == cnt - 1, "R4", "read span", last_rd - first_rd, cnt - 1);
            if (dst > 0)
                chk(dst_mem[dst-1] == sentinel(dst-1), "R3", "word below block", dst_mem[dst-1], sentinel(dst-1));
            if (dst + cnt < DEPTH)
                chk(dst_mem[dst+cnt] == sentinel(dst+cnt), "R3", "word above block",
                    dst_mem[dst+cnt], sentinel(dst+cnt));
        end else begin
            chk(rd_seen == 0, "R7", "reads on refused transfer", rd_seen, 0);
        end
    endtask

    task automatic run(input int src, input int dst, input int cnt, input bit err, input bit hold);
        expect_copy(src, dst, cnt, err);
        send(2'd0, DW'(src));
        send(2'd1, DW'(dst));
        send(2'd2, DW'(cnt));
        send(2'd3, '0);
        finish_xfer(dst, cnt, err, hold);
    endtask

    task automatic expect_idle(input string req, input string what);
        rd_seen = 0;
        repeat (8) @(negedge clk);
        chk(rd_seen == 0 && !sts_valid && !wr_en, req, what, rd_seen, 0);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) begin
            src_mem[a] = '0;
            dst_mem[a] = sentinel(a);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
        chk(sts_valid == 1'b0, "R1", "sts_valid after reset", sts_valid, 0);
        chk(rd_en == 1'b0 && wr_en == 1'b0, "R1", "memory strobes after reset", {rd_en, wr_en}, 0);

        run(10, 20, 16, 1'b0, 1'b0);        // R3 R4 basic copy
        run(0, 1000, 1, 1'b0, 1'b0);        // single word
        run(1016, 0, 8, 1'b0, 1'b0);        // source ends at top address
        run(3, 1016, 8, 1'b0, 1'b0);        // destination ends at top address
        run(5, 1017, 8, 1'b1, 1'b0);        // R7 destination overrun
        run(1020, 0, 8, 1'b1, 1'b0);        // R7 source overrun
        run(3, 4, 0, 1'b1, 1'b0);           // R7 zero count
        run(40, 60, 3, 1'b0, 1'b1);         // R6 status held

        // R2 ordering: count first and go, then partial fields and go
        send(2'd2, 32'd5);
        send(2'd3, '0);
        expect_idle("R2", "go with no fields");
        send(2'd0, 32'd100);
        send(2'd2, 32'd9);                  // out of order: ignored
        send(2'd1, 32'd200);
        send(2'd3, '0);
        expect_idle("R2", "go without count");
        expect_copy(100, 200, 4, 1'b0);
        send(2'd2, 32'd4);
        send(2'd3, '0);
        finish_xfer(200, 4, 1'b0, 1'b0);

        // R8 fields dropped after status
        send(2'd3, '0);
        expect_idle("R8", "bare go after completion");
        send(2'd0, 32'd7);
        send(2'd1, 32'd8);
        send(2'd3, '0);
        expect_idle("R8", "go with only two fresh fields");
        expect_copy(7, 8, 2, 1'b0);
        send(2'd2, 32'd2);
        send(2'd3, '0);
        finish_xfer(8, 2, 1'b0, 1'b0);

        run(0, 512, 200, 1'b0, 1'b0);       // long burst R4

        summary();
        $finish;
    end

endmodule